// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Sequencer

This block holds the processor-side interrupt state together with a chain of per-device acknowledge cells. Every device drives its request onto one wired-OR line. The sequencer looks at that line only when an instruction has finished. If the line is active and interrupts are enabled, the sequencer sends a one-cycle acknowledge into the chain. A cell whose device is requesting keeps the acknowledge. A cell whose device is idle passes it on to the next cell. The first requesting device in chain order therefore wins, so chain position alone sets priority.

The winning cell registers its grant and drives its device's handler address onto the shared vector bus in the cycle after the acknowledge. The sequencer then writes the return PC into a dedicated K0 register, leaves the enable bit cleared and issues a PC write carrying the vector. A return command writes K0 back to the PC and sets the enable bit again. Explicit enable and disable commands change the bit directly. The datapath stalls while `busy_o` is high.

Top module: `irq_daisy_seq`

## Requirements
- R1: The request line is the OR of all `dev_req_i` bits, so a request from any single device, or from several at once, can start an interrupt.
- R2: Requests are acted on only in the boundary cycle, which is the cycle after `instr_done_i` was high. A request that rises and falls while an instruction runs produces no acknowledge.
- R3: An interrupt is taken only when `int_en_o` is 1 in the boundary cycle. While it is 0, requests cause no acknowledge.
- R4: After taking an interrupt, `ack_o` is high for exactly one cycle, the cycle after the boundary. In the next cycle `dev_ack_o` is one-hot at the lowest-index device that was requesting during the acknowledge, where bit 0 is the head of the chain.
- R5: One cycle after the grant, `pc_wr_o` pulses for one cycle and `pc_wr_data_o` holds the winning device's vector. That vector is taken from slice `dev_vec_i[k*AW +: AW]` for device k.
- R6: When an interrupt is taken, `int_en_o` clears in the acknowledge cycle. When the vector is loaded, `k0_o` takes the `pc_i` value that was present in the boundary cycle.
- R7: A return command in the boundary cycle pulses `pc_wr_o` with `pc_wr_data_o` equal to `k0_o` and sets `int_en_o`. It takes precedence over a pending interrupt in the same cycle, so no acknowledge follows it.
- R8: `ei_i` and `di_i` set and clear `int_en_o` when applied in the boundary cycle. They are ignored in every other cycle.
- R9: If `di_i` and a takeable interrupt occur in the same boundary cycle, the disable wins. No acknowledge follows and `int_en_o` is 0.
- R10: If no device keeps the acknowledge (a spurious request), `dev_ack_o` stays 0, the PC is not written, `k0_o` is unchanged and `int_en_o` returns to 1.
- R11: After reset `int_en_o`, `k0_o`, `pc_wr_o`, `ack_o`, `busy_o` and `dev_ack_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_done_i | input | 1 | The current instruction finishes this cycle |
| pc_i | input | AW | PC of the next instruction, held by the datapath |
| dev_req_i | input | N_DEV | Per-device interrupt request, bit 0 at the head of the chain |
| dev_vec_i | input | N_DEV*AW | Per-device handler address, device k at [k*AW +: AW] |
| ei_i | input | 1 | Enable-interrupts command |
| di_i | input | 1 | Disable-interrupts command |
| reti_i | input | 1 | Return-from-interrupt command |
| ack_o | output | 1 | Acknowledge driven into the head of the chain |
| dev_ack_o | output | N_DEV | Acknowledge kept by each device |
| pc_wr_o | output | 1 | PC write strobe |
| pc_wr_data_o | output | AW | Value to write into the PC |
| k0_o | output | AW | Saved return address |
| int_en_o | output | 1 | Interrupt enable bit |
| busy_o | output | 1 | Datapath must stall (acknowledge or vector load) |

## Verification
The take sequence is run with three request patterns: the last device alone, two devices in the middle, and all devices together. These show whether a request anywhere on the line is seen, and whether the head-most requester wins over one further down the chain. A request that drops during the acknowledge checks the spurious path, separately from a normal take. Commands are applied both mid-instruction and at the boundary, and together with pending requests. These cases show whether the boundary gating works and which command wins when several coincide (return over interrupt, disable over interrupt).

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_FETCH_BOUNDARY = 2'd0,
    ST_ACK            = 2'd1,
    ST_LOAD_VECTOR    = 2'd2,
    ST_EXECUTE        = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_ack_cell.sv
module irq_ack_cell #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic [AW-1:0] vec_i,
  output logic          ack_o,
  output logic          grant_o,
  output logic [AW-1:0] drive_o
);
  logic grant_q;

  // requesting cell absorbs the acknowledge
  assign ack_o = ack_i & ~req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_q <= 1'b0;
    else         grant_q <= ack_i & req_i;
  end

  assign grant_o = grant_q;
  assign drive_o = grant_q ? vec_i : '0;
endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain #(
  parameter int N_DEV = 4,
  parameter int AW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ack_i,
  input  logic [N_DEV-1:0]    req_i,
  input  logic [N_DEV*AW-1:0] vec_i,
  output logic [N_DEV-1:0]    grant_o,
  output logic [AW-1:0]       vec_o,
  output logic                found_o
);
  logic [N_DEV:0]         ack_link;
  logic [N_DEV:0][AW-1:0] vec_acc;
  logic [N_DEV-1:0][AW-1:0] drive;

  assign ack_link[0] = ack_i;
  assign vec_acc[0]  = '0;

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    irq_ack_cell #(.AW(AW)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i[g]),
      .ack_i   (ack_link[g]),
      .vec_i   (vec_i[g*AW +: AW]),
      .ack_o   (ack_link[g+1]),
      .grant_o (grant_o[g]),
      .drive_o (drive[g])
    );
    // shared bus modelled as OR of gated drivers
    assign vec_acc[g+1] = vec_acc[g] | drive[g];
  end

  assign vec_o   = vec_acc[N_DEV];
  assign found_o = |grant_o;
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_done_i,
  input  logic          irq_i,
  input  logic [AW-1:0] pc_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          reti_i,
  input  logic          found_i,
  input  logic [AW-1:0] vec_i,
  output logic          ack_o,
  output logic          pc_wr_o,
  output logic [AW-1:0] pc_wr_data_o,
  output logic [AW-1:0] k0_o,
  output logic          int_en_o,
  output logic          busy_o,
  output seq_state_e    state_o
);
  seq_state_e    state_q;
  logic          en_q;
  logic [AW-1:0] k0_q;
  logic [AW-1:0] pc_hold_q;
  logic          pc_wr_q;
  logic [AW-1:0] pc_wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_EXECUTE;
      en_q         <= 1'b0;
      k0_q         <= '0;
      pc_hold_q    <= '0;
      pc_wr_q      <= 1'b0;
      pc_wr_data_q <= '0;
    end else begin
      pc_wr_q <= 1'b0;
      unique case (state_q)
        ST_EXECUTE: begin
          if (instr_done_i) state_q <= ST_FETCH_BOUNDARY;
        end
        ST_FETCH_BOUNDARY: begin
          state_q <= ST_EXECUTE;
          if (reti_i) begin
            pc_wr_q      <= 1'b1;
            pc_wr_data_q <= k0_q;
            en_q         <= 1'b1;
          end else if (di_i) begin
            en_q <= 1'b0;
          end else if (en_q && irq_i) begin
            en_q      <= 1'b0;
            pc_hold_q <= pc_i;
            state_q   <= ST_ACK;
          end else if (ei_i) begin
            en_q <= 1'b1;
          end
        end
        ST_ACK: state_q <= ST_LOAD_VECTOR;
        ST_LOAD_VECTOR: begin
          state_q <= ST_EXECUTE;
          if (found_i) begin
            k0_q         <= pc_hold_q;
            pc_wr_q      <= 1'b1;
            pc_wr_data_q <= vec_i;
          end else begin
            en_q <= 1'b1;  // spurious: nothing to return from
          end
        end
        default: state_q <= ST_EXECUTE;
      endcase
    end
  end

  assign ack_o        = (state_q == ST_ACK);
  assign busy_o       = (state_q == ST_ACK) || (state_q == ST_LOAD_VECTOR);
  assign pc_wr_o      = pc_wr_q;
  assign pc_wr_data_o = pc_wr_data_q;
  assign k0_o         = k0_q;
  assign int_en_o     = en_q;
  assign state_o      = state_q;
endmodule

// File: rtl/irq_daisy_seq.sv
module irq_daisy_seq
  import irq_seq_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int AW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_done_i,
  input  logic [AW-1:0]       pc_i,
  input  logic [N_DEV-1:0]    dev_req_i,
  input  logic [N_DEV*AW-1:0] dev_vec_i,
  input  logic                ei_i,
  input  logic                di_i,
  input  logic                reti_i,
  output logic                ack_o,
  output logic [N_DEV-1:0]    dev_ack_o,
  output logic                pc_wr_o,
  output logic [AW-1:0]       pc_wr_data_o,
  output logic [AW-1:0]       k0_o,
  output logic                int_en_o,
  output logic                busy_o
);
  logic          irq_line;
  logic          ack_w;
  logic          found_w;
  logic [AW-1:0] vec_bus;
  seq_state_e    seq_state;

  assign irq_line = |dev_req_i;

  irq_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .instr_done_i (instr_done_i),
    .irq_i        (irq_line),
    .pc_i         (pc_i),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .reti_i       (reti_i),
    .found_i      (found_w),
    .vec_i        (vec_bus),
    .ack_o        (ack_w),
    .pc_wr_o      (pc_wr_o),
    .pc_wr_data_o (pc_wr_data_o),
    .k0_o         (k0_o),
    .int_en_o     (int_en_o),
    .busy_o       (busy_o),
    .state_o      (seq_state)
  );

  irq_ack_chain #(.N_DEV(N_DEV), .AW(AW)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_i   (ack_w),
    .req_i   (dev_req_i),
    .vec_i   (dev_vec_i),
    .grant_o (dev_ack_o),
    .vec_o   (vec_bus),
    .found_o (found_w)
  );

  assign ack_o = ack_w;
endmodule

// File: rtl/irq_daisy_seq_chk.sv
module irq_daisy_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DEV-1:0] dev_req_i,
  input logic             di_i,
  input logic             reti_i,
  input logic             ack_o,
  input logic [N_DEV-1:0] dev_ack_o,
  input logic             int_en_o,
  input seq_state_e       state_i
);
  a_r4_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r4_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_ack_o));

  a_r4_grant_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dev_ack_o) |-> $past(ack_o));

  a_r3_take_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(int_en_o && (|dev_req_i)));

  a_r2_take_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(state_i == ST_FETCH_BOUNDARY));

  a_r6_en_clear_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !int_en_o);

  a_r9_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH_BOUNDARY && di_i && !reti_i) |=> (!ack_o && !int_en_o));

  a_r8_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXECUTE) |=> $stable(int_en_o));
endmodule

bind irq_daisy_seq irq_daisy_seq_chk #(.N_DEV(N_DEV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dev_req_i (dev_req_i),
  .di_i      (di_i),
  .reti_i    (reti_i),
  .ack_o     (ack_o),
  .dev_ack_o (dev_ack_o),
  .int_en_o  (int_en_o),
  .state_i   (seq_state)
);

// File: tb/irq_daisy_seq_test.sv
module irq_daisy_seq_test;
  localparam int N_DEV  = 4;
  localparam int AW     = 32;
  localparam int CLK_NS = 10;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                instr_done_i = 1'b0;
  logic [AW-1:0]       pc_i = '0;
  logic [N_DEV-1:0]    dev_req_i = '0;
  logic [N_DEV*AW-1:0] dev_vec_i = '0;
  logic                ei_i = 1'b0, di_i = 1'b0, reti_i = 1'b0;
  logic                ack_o, pc_wr_o, int_en_o, busy_o;
  logic [N_DEV-1:0]    dev_ack_o;
  logic [AW-1:0]       pc_wr_data_o, k0_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  irq_daisy_seq #(.N_DEV(N_DEV), .AW(AW)) uut (.*);

  function automatic logic [AW-1:0] vec_of(input int k);
    return 32'h0000_8000 + 32'h100 * k;
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ends after the edge that evaluates the boundary cycle
  task automatic at_boundary(input logic e, input logic d, input logic r);
    @(negedge clk_i); instr_done_i = 1'b1;
    @(negedge clk_i); instr_done_i = 1'b0; ei_i = e; di_i = d; reti_i = r;
    @(negedge clk_i); ei_i = 1'b0; di_i = 1'b0; reti_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 en", int_en_o, 0);
    chk("R11 k0", k0_o, 0);
    chk("R11 pc_wr", pc_wr_o, 0);
    chk("R11 ack", ack_o, 0);
    chk("R11 busy", busy_o, 0);
    chk("R11 dev_ack", dev_ack_o, 0);
  endtask

  task automatic t_disabled();
    dev_req_i = 4'b0100;
    at_boundary(0, 0, 0);
    chk("R3 no ack when disabled", ack_o, 0);
    @(negedge clk_i);
    chk("R3 no grant when disabled", dev_ack_o, 0);
    dev_req_i = '0;
  endtask

  task automatic t_enable_cmds();
    @(negedge clk_i); ei_i = 1'b1;
    @(negedge clk_i); ei_i = 1'b0;
    chk("R8 ei mid-instruction ignored", int_en_o, 0);
    at_boundary(1, 0, 0);
    chk("R8 ei at boundary sets", int_en_o, 1);
    @(negedge clk_i); di_i = 1'b1;
    @(negedge clk_i); di_i = 1'b0;
    chk("R8 di mid-instruction ignored", int_en_o, 1);
  endtask

  task automatic t_mid_request();
    @(negedge clk_i); dev_req_i = 4'b0010;
    @(negedge clk_i); chk("R2 no ack mid-instruction", ack_o, 0);
    @(negedge clk_i); dev_req_i = '0;
    chk("R2 no ack mid-instruction", ack_o, 0);
    at_boundary(0, 0, 0);
    chk("R2 dropped request not taken", ack_o, 0);
  endtask

  task automatic t_take(input logic [N_DEV-1:0] mask, input int winner, input logic [AW-1:0] pc);
    pc_i = pc;
    dev_req_i = mask;
    at_boundary(0, 0, 0);
    chk("R1 request line starts take", ack_o, 1);
    chk("R6 enable cleared in ack", int_en_o, 0);
    chk("R4 busy during ack", busy_o, 1);
    @(negedge clk_i);
    chk("R4 ack one cycle", ack_o, 0);
    chk("R4 winner by chain position", dev_ack_o, 1 << winner);
    @(negedge clk_i);
    chk("R5 pc write strobe", pc_wr_o, 1);
    chk("R5 vector of winner", pc_wr_data_o, vec_of(winner));
    chk("R6 k0 saved", k0_o, pc);
    chk("R6 enable stays clear", int_en_o, 0);
    dev_req_i = '0;
    pc_i = 32'hdead_0000;
    @(negedge clk_i);
    chk("R5 pc write one cycle", pc_wr_o, 0);
    at_boundary(0, 0, 1);
    chk("R7 return writes pc", pc_wr_o, 1);
    chk("R7 return value", pc_wr_data_o, pc);
    chk("R7 return sets enable", int_en_o, 1);
  endtask

  task automatic t_disable_wins();
    dev_req_i = 4'b0001;
    at_boundary(0, 1, 0);
    chk("R9 no ack", ack_o, 0);
    chk("R9 enable cleared", int_en_o, 0);
    dev_req_i = '0;
    at_boundary(1, 0, 0);
    chk("R8 re-enable", int_en_o, 1);
  endtask

  task automatic t_spurious();
    logic [AW-1:0] k0_prev;
    k0_prev = k0_o;
    pc_i = 32'h0000_0777;
    dev_req_i = 4'b0100;
    at_boundary(0, 0, 0);
    chk("R10 ack issued", ack_o, 1);
    dev_req_i = '0;  // withdrawn while acknowledge travels
    @(negedge clk_i);
    chk("R10 no keeper", dev_ack_o, 0);
    @(negedge clk_i);
    chk("R10 no pc write", pc_wr_o, 0);
    chk("R10 k0 unchanged", k0_o, k0_prev);
    chk("R10 enable restored", int_en_o, 1);
  endtask

  task automatic t_reti_wins();
    logic [AW-1:0] k0_prev;
    k0_prev = k0_o;
    dev_req_i = 4'b0010;
    at_boundary(0, 0, 1);
    chk("R7 return beats interrupt: no ack", ack_o, 0);
    chk("R7 return beats interrupt: pc write", pc_wr_o, 1);
    chk("R7 return beats interrupt: value", pc_wr_data_o, k0_prev);
    chk("R7 return beats interrupt: enable", int_en_o, 1);
    dev_req_i = '0;
  endtask

  initial begin
    for (int k = 0; k < N_DEV; k++) dev_vec_i[k*AW +: AW] = vec_of(k);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_disabled();
    t_enable_cmds();
    t_mid_request();
    t_take(4'b1000, 3, 32'h0000_1234);
    t_take(4'b0110, 1, 32'h0000_2468);
    t_take(4'b1111, 0, 32'h0000_3690);
    t_disable_wins();
    t_spurious();
    t_reti_wins();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule